// File: doc/BRIEF.md
# Pack/Unpack Element Offset Sequencer

This block produces the element offsets for a vector register move that works on short subvectors of one to four elements. A start pulse loads a vector length, a subvector length and two mode bits. From the next cycle on, the block presents one source offset and one destination offset per cycle. The consumer moves element `base_a + src` into element `base_t + dst`. The block stops after vector length × subvector length pairs.

Two independent offset walkers run in lock-step from a shared step index k. The index counts with the vector index i in the outer loop and the subvector index j in the inner loop, so k = i*SUBVL + j. A walker in plain order emits i*SUBVL + j. A walker in transposed order emits i + VL*j, which gathers from or scatters to a plane-per-component layout. The pack bit switches the source walker to transposed order. The unpack bit does the same for the destination walker. Both bits may be set together.

Each offset pair is handed over with a valid/ready handshake. A one-cycle done pulse marks the end of the sequence.

Top module: `pu_offset_seq`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` and `done_o` are low.
- R2: With both mode bits clear, the pair at step k is src = dst = k, for k = 0 .. VL*SUBVL-1.
- R3: With `pack_en_i` set, the source offset at step k is i + VL*j, where i = k / SUBVL and j = k mod SUBVL. The destination stays at k.
- R4: With `unpack_en_i` set, the destination offset at step k is i + VL*j. The source stays at k.
- R5: With both mode bits set, source and destination both follow i + VL*j and are equal at every step.
- R6: `subvl_m1_i` holds the subvector length minus one (0..3 means 1..4). Exactly VL*SUBVL pairs are accepted, and `valid_o` is low in the cycle after the last one.
- R7: `done_o` is high for exactly the cycle in which the last pair is accepted (`valid_o` and `ready_i` both high).
- R8: A start with VL = 0 gives no valid pair. `done_o` is high for one cycle, in the cycle after the start.
- R9: While `valid_o` is high and `ready_i` is low, both offsets hold and the sequence does not advance.
- R10: VL, SUBVL and the mode bits are captured at an accepted start. Input changes and start pulses while a sequence runs have no effect on the offsets emitted.
- R11: VL = 64 with SUBVL = 4 is handled in full, with offsets reaching 255.
- R12: The first pair (offsets 0, 0) is valid in the cycle right after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when no sequence is running |
| vl_i | input | 7 | Vector length, 0..64 |
| subvl_m1_i | input | 2 | Subvector length minus one |
| pack_en_i | input | 1 | Source walker uses transposed order |
| unpack_en_i | input | 1 | Destination walker uses transposed order |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | An offset pair is presented |
| src_off_o | output | 8 | Source element offset |
| dst_off_o | output | 8 | Destination element offset |
| done_o | output | 1 | Last pair accepted, or an empty sequence ended |

## Verification
The hardest situation to reach is a transposed walker's wrap from the last subvector component of one vector element to component zero of the next. That wrap must land exactly when the consumer stalls, or when a foreign start request arrives mid-sequence. The stimulus reaches it by combining transposed modes with a ready pattern that drops one cycle in three, so stalls fall on both wrap and non-wrap steps. A separate run drives a changed configuration and a start pulse while busy, then compares every pair with the sequence computed from the captured configuration.

// File: rtl/pu_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the captured configuration record for the
// pack/unpack offset sequencer. Assumes SUBVL_MAX is a power of two.
package pu_seq_pkg;
    localparam int unsigned VL_MAX    = 64;
    localparam int unsigned SUBVL_MAX = 4;
    localparam int unsigned VL_W      = $clog2(VL_MAX + 1);
    localparam int unsigned SL_W      = $clog2(SUBVL_MAX);
    localparam int unsigned OFF_W     = $clog2(VL_MAX * SUBVL_MAX);
    localparam int unsigned CNT_W     = OFF_W + 1;
    localparam int unsigned N_WALK    = 2;

    typedef struct packed {
        logic            pack;
        logic            unpack;
        logic [VL_W-1:0] vl;
        logic [SL_W-1:0] sl_m1;
    } seq_cfg_t;
endpackage

// File: rtl/pu_walker.sv
`timescale 1ns/1ps
// Module: pu_walker
// Produces one element offset per step, walking i (outer) and j (inner).
// Plain order emits i*SUBVL+j, and transposed order emits i+VL*j. Both are
// built incrementally, so no multiplier is needed.
// Assumes: load_i and step_i are never high together, and vl_i, sl_m1_i and
// trans_i stay fixed between a load and the end of the sequence.
module pu_walker
    import pu_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             trans_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [SL_W-1:0]  sl_m1_i,
    output logic [OFF_W-1:0] off_o
);
    logic [VL_W-1:0]  i_q;
    logic [SL_W-1:0]  j_q;
    logic [OFF_W-1:0] off_q;
    logic             j_wrap;

    // Purpose: the inner index has reached the last subvector component.
    assign j_wrap = (j_q == sl_m1_i);

    // Purpose: advance the indices and the running offset by one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q   <= '0;
            j_q   <= '0;
            off_q <= '0;
        end else if (load_i) begin
            i_q   <= '0;
            j_q   <= '0;
            off_q <= '0;
        end else if (step_i) begin
            if (j_wrap) begin
                j_q   <= '0;
                i_q   <= i_q + VL_W'(1);
                off_q <= trans_i ? (OFF_W'(i_q) + OFF_W'(1)) : (off_q + OFF_W'(1));
            end else begin
                j_q   <= j_q + SL_W'(1);
                off_q <= trans_i ? (off_q + OFF_W'(vl_i)) : (off_q + OFF_W'(1));
            end
        end
    end

    assign off_o = off_q;

    // R2: in plain order every step moves the offset by exactly one
    a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !trans_i) |=> (off_o == $past(off_o) + OFF_W'(1)));

    // R3: in transposed order a step inside a subvector jumps by VL
    a_r3_trans_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && trans_i && !j_wrap) |=> (off_o == $past(off_o) + OFF_W'($past(vl_i))));

    // R12: a load restarts the walk at offset zero
    a_r12_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (off_o == '0));
endmodule

// File: rtl/pu_seq_ctrl.sv
`timescale 1ns/1ps
// Module: pu_seq_ctrl
// Accepts a start when idle and holds the configuration. It counts accepted
// pairs against VL*SUBVL and drives valid, step, load and done.
// Assumes: ready_i may change freely; a start while busy is dropped.
module pu_seq_ctrl
    import pu_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  seq_cfg_t cfg_i,
    input  logic     ready_i,
    output seq_cfg_t cfg_o,
    output logic     load_o,
    output logic     step_o,
    output logic     valid_o,
    output logic     done_o
);
    seq_cfg_t         cfg_q;
    logic             busy_q;
    logic             empty_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] total;
    logic             accept;
    logic             at_last;

    // Purpose: a start is taken only when no sequence is running.
    assign accept = start_i && !busy_q;

    // Purpose: number of pairs the requested sequence will produce.
    assign total = CNT_W'(cfg_i.vl) * (CNT_W'(cfg_i.sl_m1) + CNT_W'(1));

    // Purpose: the pair on the outputs is the final one.
    assign at_last = (cnt_q == last_q);

    // Purpose: capture the configuration and track the progress of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            busy_q  <= 1'b0;
            empty_q <= 1'b0;
            cnt_q   <= '0;
            last_q  <= '0;
        end else begin
            empty_q <= accept && (cfg_i.vl == '0);
            if (accept) begin
                cfg_q  <= cfg_i;
                cnt_q  <= '0;
                last_q <= total - CNT_W'(1);
                busy_q <= (cfg_i.vl != '0);
            end else if (step_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (at_last) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign cfg_o   = cfg_q;
    assign load_o  = accept;
    assign valid_o = busy_q;
    assign step_o  = busy_q && ready_i;
    assign done_o  = (step_o && at_last) || empty_q;

    // R6: the pair counter never passes the last index of the sequence
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= last_q));

    // R7: once the final pair completes, valid drops on the next cycle
    a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && done_o) |=> !valid_o);

    // R8: an empty sequence yields done without a valid pair
    a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cfg_i.vl == '0)) |=> (done_o && !valid_o));

    // R10: the configuration in use holds while a sequence runs
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !(done_o)) |=> $stable(cfg_q));
endmodule

// File: rtl/pu_offset_seq.sv
`timescale 1ns/1ps
// Module: pu_offset_seq (top)
// Pack/unpack element offset sequencer. One controller and two lock-step
// walkers; walker 0 drives the source offset (transposed when pack is set)
// and walker 1 drives the destination offset (transposed when unpack is set).
// Assumes: subvl_m1_i encodes subvector length minus one.
module pu_offset_seq
    import pu_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [SL_W-1:0]  subvl_m1_i,
    input  logic             pack_en_i,
    input  logic             unpack_en_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [OFF_W-1:0] src_off_o,
    output logic [OFF_W-1:0] dst_off_o,
    output logic             done_o
);
    seq_cfg_t                      cfg_in;
    seq_cfg_t                      cfg_q;
    logic                          load;
    logic                          step;
    logic [N_WALK-1:0][OFF_W-1:0]  offs;
    logic [N_WALK-1:0]             trans;

    // Purpose: gather the start-time configuration.
    assign cfg_in = '{pack: pack_en_i, unpack: unpack_en_i, vl: vl_i, sl_m1: subvl_m1_i};

    pu_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .cfg_i   (cfg_in),
        .ready_i (ready_i),
        .cfg_o   (cfg_q),
        .load_o  (load),
        .step_o  (step),
        .valid_o (valid_o),
        .done_o  (done_o)
    );

    // Purpose: one walker per side, each picking its own order bit.
    for (genvar w = 0; w < N_WALK; w++) begin : g_walk
        assign trans[w] = (w == 0) ? cfg_q.pack : cfg_q.unpack;
        pu_walker u_walker (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .step_i  (step),
            .trans_i (trans[w]),
            .vl_i    (cfg_q.vl),
            .sl_m1_i (cfg_q.sl_m1),
            .off_o   (offs[w])
        );
    end

    assign src_off_o = offs[0];
    assign dst_off_o = offs[1];

    // R9: a stalled pair stays on the outputs unchanged
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(src_off_o) && $stable(dst_off_o)));

    // R5: both walkers in the same order give identical offsets
    a_r5_same_order: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (cfg_q.pack == cfg_q.unpack)) |-> (src_off_o == dst_off_o));

    // R1: no pair and no done straight after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !done_o));
endmodule

// File: tb/pu_offset_seq_bench.sv
`timescale 1ns/1ps
module pu_offset_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] vl_i = '0;
    logic [1:0] subvl_m1_i = '0;
    logic       pack_en_i = 1'b0;
    logic       unpack_en_i = 1'b0;
    logic       ready_i = 1'b0;
    logic       valid_o;
    logic [7:0] src_off_o;
    logic [7:0] dst_off_o;
    logic       done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pu_offset_seq u_pu_offset_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .vl_i        (vl_i),
        .subvl_m1_i  (subvl_m1_i),
        .pack_en_i   (pack_en_i),
        .unpack_en_i (unpack_en_i),
        .ready_i     (ready_i),
        .valid_o     (valid_o),
        .src_off_o   (src_off_o),
        .dst_off_o   (dst_off_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_off(input int k, input int vl, input int sl, input bit tr);
        int i = k / sl;
        int j = k % sl;
        return tr ? (i + vl * j) : k;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One full sequence, checked pair by pair against the model
    task automatic t_seq(input string tag, input int vl, input int sl, input bit pk,
                         input bit up, input bit stall, input bit disturb);
        int total = vl * sl;
        int k = 0;
        int cyc = 0;
        vl_i = 7'(vl);
        subvl_m1_i = 2'(sl - 1);
        pack_en_i = pk;
        unpack_en_i = up;
        ready_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        while (k < total && cyc < 4000) begin
            ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
            if (disturb && cyc == 2) begin
                start_i = 1'b1;
                vl_i = 7'd5;
                subvl_m1_i = 2'(sl % 4);
                pack_en_i = !pk;
                unpack_en_i = !up;
            end else begin
                start_i = 1'b0;
            end
            #0.5;
            chk(valid_o == 1'b1, (k == 0) ? "R12 first valid" : tag, int'(valid_o), 1);
            chk(int'(src_off_o) == exp_off(k, vl, sl, pk), {tag, " src"}, int'(src_off_o), exp_off(k, vl, sl, pk));
            chk(int'(dst_off_o) == exp_off(k, vl, sl, up), {tag, " dst"}, int'(dst_off_o), exp_off(k, vl, sl, up));
            chk(done_o == (ready_i && k == total - 1), "R7 done", int'(done_o), int'(ready_i && k == total - 1));
            if (ready_i) k++;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        ready_i = 1'b1;
        #0.5;
        chk(valid_o == 1'b0, "R6 sequence length", int'(valid_o), 0);
        chk(done_o == 1'b0, "R6 no extra done", int'(done_o), 0);
        @(negedge clk);
    endtask

    // R8: an empty vector
    task automatic t_empty();
        vl_i = '0;
        subvl_m1_i = 2'd2;
        pack_en_i = 1'b1;
        unpack_en_i = 1'b0;
        ready_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #0.5;
        chk(valid_o == 1'b0, "R8 no valid", int'(valid_o), 0);
        chk(done_o == 1'b1, "R8 done", int'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done single", int'(done_o), 0);
        chk(valid_o == 1'b0, "R8 still idle", int'(valid_o), 0);
    endtask

    initial begin
        t_reset();
        t_seq("R2 plain", 4, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        t_seq("R3 pack", 4, 3, 1'b1, 1'b0, 1'b0, 1'b0);
        t_seq("R4 unpack", 5, 4, 1'b0, 1'b1, 1'b0, 1'b0);
        t_seq("R5 both", 3, 2, 1'b1, 1'b1, 1'b0, 1'b0);
        t_seq("R5 both sl4", 1, 4, 1'b1, 1'b1, 1'b0, 1'b0);
        t_seq("R6 sl1", 7, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        t_seq("R9 stall", 4, 3, 1'b1, 1'b1, 1'b1, 1'b0);
        t_seq("R9 stall mixed", 5, 2, 1'b0, 1'b1, 1'b1, 1'b0);
        t_seq("R10 capture", 6, 2, 1'b0, 1'b1, 1'b0, 1'b1);
        t_empty();
        t_seq("R11 max", 64, 4, 1'b1, 1'b0, 1'b0, 1'b0);
        t_seq("R11 max unpack", 64, 4, 1'b0, 1'b1, 1'b1, 1'b0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule